// File: doc/BRIEF.md
# SCSI Host Adapter Command Register Model

This block is the register front end of a small SCSI host adapter. A CPU-side bus writes and reads byte-wide adapter registers. Writes go into a write bank and reads come from a separate read bank, and both banks sit at the same addresses. A write to the command register is decoded, and the status, interrupt and sequence registers in the read bank are loaded with codes that depend on the command. A second bank of 32-bit DMA control registers sets the interrupt handshake. Completion sets bit 0 of DMA register 0 and raises the interrupt line. A later write to that register with bit 4 clear drops the line.

Commands that move data wait for a one-cycle transfer-done pulse from the outside before they post their codes. Until the pulse arrives the block is busy and ignores further commands. The select commands check a per-target present vector. If the addressed target is absent, the select finishes at once with a disconnect. The transfer length is built from write registers 0 and 1 and is offered to the data mover.

Top module: `hba_cmd_regfile`

## Requirements
- R1: Every adapter write is stored in the write bank at index address[5:2]. The transfer-length output is {write[1], write[0]}. The select target ID is write[4][2:0].
- R2: After reset the read bank is all zero except index 0x0E, which holds 0x04. All four DMA registers are zero, the interrupt is low and the block is not busy.
- R3: Only bits [6:0] of a write to index 3 select the command. Bit 7 has no effect on decoding.
- R4: Command 0x01 sets the interrupt register (index 5) to 0x08 and the sequence register (index 6) to 0x00. It leaves the status register (index 4) as it was and does not touch the interrupt line.
- R5: Command 0x02 restores the read bank and the DMA registers to their reset values. It keeps the write bank and the interrupt line as they were.
- R6: Commands 0x00, 0x03 and 0x1A, and every code the block does not decode, change no read register and no DMA register and raise no interrupt.
- R7: Commands 0x42 and 0x43 finish at once, without becoming busy, when the target ID is above 4 or its present bit is 0. In that case status becomes 0x80, interrupt becomes 0x20 and sequence becomes 0x00.
- R8: Commands 0x42 and 0x43 with a present target ID of 4 or below make the block busy. The next transfer-done pulse then sets status to 0x91, interrupt to 0x18 and sequence to 0x04, and ends the busy state.
- R9: After the transfer-done pulse, commands 0x10, 0x11 and 0x12 post (status, interrupt, sequence) as follows: 0x10 gives (0x93, 0x10, 0x00), 0x11 gives (0x93, 0x18, 0x04) and 0x12 gives (0x93, 0x20, 0x00).
- R10: While the block is busy, command writes are ignored, although the byte is still stored in the write bank. A transfer-done pulse while the block is idle has no effect.
- R11: Every completion that posts codes (R7 to R9) sets bit 0 of DMA register 0 and asserts the interrupt on the next clock edge. A DMA write stores all 32 bits. A write to DMA register 0 with bit 4 clear lowers the interrupt. With bit 4 set, the interrupt is left as it was.
- R12: If a completion falls in the same cycle as a write to DMA register 0, the stored value is the written value with bit 0 forced to 1, and the interrupt ends up asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipWrEn | input | 1 | Adapter register write strobe |
| chipAddr | input | 6 | Adapter byte address; register index is bits [5:2] |
| chipWrData | input | 8 | Adapter write data |
| chipRdData | output | 8 | Read-bank contents at chipAddr (combinational) |
| dmaWrEn | input | 1 | DMA control register write strobe |
| dmaAddr | input | 4 | DMA byte address; register index is bits [3:2] |
| dmaWrData | input | 32 | DMA control write data |
| dmaRdData | output | 32 | DMA control register at dmaAddr (combinational) |
| targetPresent | input | 8 | One present bit per target ID |
| xferDone | input | 1 | One-cycle pulse marking the end of the data movement |
| cmdBusy | output | 1 | A command is waiting for xferDone |
| irq | output | 1 | Interrupt request |
| xferLen | output | 16 | Transfer length from write registers 1:0 |

## Verification
Two events can fall in the same clock cycle: a completion, whether from a transfer-done pulse or from an immediate select failure, and a CPU write to DMA register 0 that tries to lower the interrupt. The random phase drives DMA writes, done pulses and command writes independently in every cycle, so these overlaps happen often. A directed case also forces the overlap with bit 4 clear. The bench judges the result by reading back DMA register 0 and the interrupt line. Bit 0 must be 1 on top of the written value, and the interrupt must stay high.

// File: rtl/hba_cmd_pkg.sv
package hba_cmd_pkg;

  // register indices whose position the decode depends on
  localparam int unsigned IDX_LEN_LO = 0;
  localparam int unsigned IDX_LEN_HI = 1;
  localparam int unsigned IDX_CMD    = 3;
  localparam int unsigned IDX_STAT   = 4;
  localparam int unsigned IDX_TGT    = 4;
  localparam int unsigned IDX_INTR   = 5;
  localparam int unsigned IDX_SEQ    = 6;
  localparam int unsigned IDX_ID     = 14;
  localparam logic [7:0]  ID_VALUE   = 8'h04;

  // command codes (low seven bits of the command byte)
  typedef enum logic [6:0] {
    OP_NOP      = 7'h00,
    OP_FLUSH    = 7'h01,
    OP_CHIPRST  = 7'h02,
    OP_BUSRST   = 7'h03,
    OP_XFER     = 7'h10,
    OP_CMPLSEQ  = 7'h11,
    OP_MSGACC   = 7'h12,
    OP_SETATN   = 7'h1A,
    OP_SELATN   = 7'h42,
    OP_SELSTOP  = 7'h43
  } hbaOp_t;

  // status bits
  localparam logic [7:0] ST_IRQ      = 8'h80;
  localparam logic [7:0] ST_CNTZERO  = 8'h10;
  localparam logic [7:0] PH_DATAIN   = 8'h01;
  localparam logic [7:0] PH_STATUS   = 8'h03;
  // interrupt bits
  localparam logic [7:0] IN_FUNCDONE = 8'h08;
  localparam logic [7:0] IN_SVCREQ   = 8'h10;
  localparam logic [7:0] IN_DISCON   = 8'h20;
  // sequence values
  localparam logic [7:0] SQ_IDLE     = 8'h00;
  localparam logic [7:0] SQ_CMDDONE  = 8'h04;

  // strobes from control to datapath
  typedef struct packed {
    logic       doReset;
    logic       loadStat;
    logic       loadIntr;
    logic       loadSeq;
    logic       raiseIrq;
    logic [7:0] statVal;
    logic [7:0] intrVal;
    logic [7:0] seqVal;
  } regStrobe_t;

  typedef enum logic {
    CS_IDLE,
    CS_WAIT
  } ctlState_t;

endpackage

// File: rtl/hba_cmd_ctrl.sv
module hba_cmd_ctrl
  import hba_cmd_pkg::*;
#(
  parameter int unsigned NUM_TGT    = 8,
  parameter int unsigned MAX_TGT_ID = 4,
  localparam int unsigned TGT_W     = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWr,
  input  logic [6:0]         cmdCode,
  input  logic [TGT_W-1:0]   tgtId,
  input  logic [NUM_TGT-1:0] targetPresent,
  input  logic               xferDone,
  output logic               busy,
  output regStrobe_t         strobe
);

  ctlState_t  state;
  logic [6:0] pendOp;
  logic       startWait;
  logic       tgtAbsent;

  assign tgtAbsent = (32'(tgtId) > MAX_TGT_ID) || !targetPresent[tgtId];
  assign busy      = (state == CS_WAIT);

  always_comb begin
    strobe    = '0;
    startWait = 1'b0;
    if (state == CS_WAIT) begin
      if (xferDone) begin
        strobe.loadStat = 1'b1;
        strobe.loadIntr = 1'b1;
        strobe.loadSeq  = 1'b1;
        strobe.raiseIrq = 1'b1;
        case (pendOp)
          OP_XFER: begin
            strobe.statVal = ST_IRQ | ST_CNTZERO | PH_STATUS;
            strobe.intrVal = IN_SVCREQ;
            strobe.seqVal  = SQ_IDLE;
          end
          OP_CMPLSEQ: begin
            strobe.statVal = ST_IRQ | ST_CNTZERO | PH_STATUS;
            strobe.intrVal = IN_SVCREQ | IN_FUNCDONE;
            strobe.seqVal  = SQ_CMDDONE;
          end
          OP_MSGACC: begin
            strobe.statVal = ST_IRQ | ST_CNTZERO | PH_STATUS;
            strobe.intrVal = IN_DISCON;
            strobe.seqVal  = SQ_IDLE;
          end
          default: begin
            strobe.statVal = ST_IRQ | ST_CNTZERO | PH_DATAIN;
            strobe.intrVal = IN_SVCREQ | IN_FUNCDONE;
            strobe.seqVal  = SQ_CMDDONE;
          end
        endcase
      end
    end else if (cmdWr) begin
      case (cmdCode)
        OP_FLUSH: begin
          strobe.loadIntr = 1'b1;
          strobe.loadSeq  = 1'b1;
          strobe.intrVal  = IN_FUNCDONE;
          strobe.seqVal   = SQ_IDLE;
        end
        OP_CHIPRST: strobe.doReset = 1'b1;
        OP_SELATN, OP_SELSTOP: begin
          if (tgtAbsent) begin
            strobe.loadStat = 1'b1;
            strobe.loadIntr = 1'b1;
            strobe.loadSeq  = 1'b1;
            strobe.raiseIrq = 1'b1;
            strobe.statVal  = ST_IRQ;
            strobe.intrVal  = IN_DISCON;
            strobe.seqVal   = SQ_IDLE;
          end else begin
            startWait = 1'b1;
          end
        end
        OP_XFER, OP_CMPLSEQ, OP_MSGACC: startWait = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= CS_IDLE;
      pendOp <= '0;
    end else begin
      if (startWait) begin
        state  <= CS_WAIT;
        pendOp <= cmdCode;
      end else if (state == CS_WAIT && xferDone) begin
        state <= CS_IDLE;
      end
    end
  end

endmodule

// File: rtl/hba_cmd_dpath.sv
module hba_cmd_dpath
  import hba_cmd_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned NUM_DMA   = 4,
  parameter int unsigned DMA_W     = 32,
  parameter int unsigned TGT_W     = 3,
  localparam int unsigned REG_IW   = $clog2(NUM_REGS),
  localparam int unsigned DMA_IW   = $clog2(NUM_DMA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipWrEn,
  input  logic [REG_IW-1:0] chipIdx,
  input  logic [7:0]        chipWrData,
  output logic [7:0]        chipRdData,
  input  logic              dmaWrEn,
  input  logic [DMA_IW-1:0] dmaIdx,
  input  logic [DMA_W-1:0]  dmaWrData,
  output logic [DMA_W-1:0]  dmaRdData,
  input  regStrobe_t        strobe,
  output logic [TGT_W-1:0]  tgtId,
  output logic [15:0]       xferLen,
  output logic              irq
);

  logic [7:0]       wrBank [NUM_REGS];
  logic [7:0]       rdBank [NUM_REGS];
  logic [DMA_W-1:0] dmaBank[NUM_DMA];
  logic             irqClear;

  assign chipRdData = rdBank[chipIdx];
  assign dmaRdData  = dmaBank[dmaIdx];
  assign tgtId      = wrBank[IDX_TGT][TGT_W-1:0];
  assign xferLen    = {wrBank[IDX_LEN_HI], wrBank[IDX_LEN_LO]};
  assign irqClear   = dmaWrEn && (dmaIdx == '0) && !dmaWrData[4];

  // write bank: every write lands, command or not
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) wrBank[i] <= '0;
    end else if (chipWrEn) begin
      wrBank[chipIdx] <= chipWrData;
    end
  end

  // read bank
  always_ff @(posedge clk) begin
    if (!rstN || strobe.doReset) begin
      for (int i = 0; i < NUM_REGS; i++)
        rdBank[i] <= (i == IDX_ID) ? ID_VALUE : 8'h00;
    end else begin
      if (strobe.loadStat) rdBank[IDX_STAT] <= strobe.statVal;
      if (strobe.loadIntr) rdBank[IDX_INTR] <= strobe.intrVal;
      if (strobe.loadSeq)  rdBank[IDX_SEQ]  <= strobe.seqVal;
    end
  end

  // DMA control bank; completion flag wins over a same-cycle write
  always_ff @(posedge clk) begin
    if (!rstN || strobe.doReset) begin
      for (int i = 0; i < NUM_DMA; i++) dmaBank[i] <= '0;
    end else begin
      if (dmaWrEn) dmaBank[dmaIdx] <= dmaWrData;
      if (strobe.raiseIrq) dmaBank[0][0] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (strobe.raiseIrq) begin
      irq <= 1'b1;
    end else if (irqClear) begin
      irq <= 1'b0;
    end
  end

endmodule

// File: rtl/hba_cmd_regfile.sv
module hba_cmd_regfile
  import hba_cmd_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 16,
  parameter int unsigned NUM_DMA    = 4,
  parameter int unsigned DMA_W      = 32,
  parameter int unsigned NUM_TGT    = 8,
  parameter int unsigned MAX_TGT_ID = 4,
  localparam int unsigned CHIP_AW   = $clog2(NUM_REGS) + 2,
  localparam int unsigned DMA_AW    = $clog2(NUM_DMA) + 2,
  localparam int unsigned TGT_W     = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chipWrEn,
  input  logic [CHIP_AW-1:0] chipAddr,
  input  logic [7:0]         chipWrData,
  output logic [7:0]         chipRdData,
  input  logic               dmaWrEn,
  input  logic [DMA_AW-1:0]  dmaAddr,
  input  logic [DMA_W-1:0]   dmaWrData,
  output logic [DMA_W-1:0]   dmaRdData,
  input  logic [NUM_TGT-1:0] targetPresent,
  input  logic               xferDone,
  output logic               cmdBusy,
  output logic               irq,
  output logic [15:0]        xferLen
);

  logic [CHIP_AW-3:0] chipIdx;
  logic [DMA_AW-3:0]  dmaIdx;
  logic               cmdWr;
  logic [TGT_W-1:0]   tgtId;
  regStrobe_t         strobe;

  assign chipIdx = chipAddr[CHIP_AW-1:2];
  assign dmaIdx  = dmaAddr[DMA_AW-1:2];
  assign cmdWr   = chipWrEn && (32'(chipIdx) == IDX_CMD);

  hba_cmd_ctrl #(
    .NUM_TGT   (NUM_TGT),
    .MAX_TGT_ID(MAX_TGT_ID)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdWr        (cmdWr),
    .cmdCode      (chipWrData[6:0]),
    .tgtId        (tgtId),
    .targetPresent(targetPresent),
    .xferDone     (xferDone),
    .busy         (cmdBusy),
    .strobe       (strobe)
  );

  hba_cmd_dpath #(
    .NUM_REGS(NUM_REGS),
    .NUM_DMA (NUM_DMA),
    .DMA_W   (DMA_W),
    .TGT_W   (TGT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .chipWrEn  (chipWrEn),
    .chipIdx   (chipIdx),
    .chipWrData(chipWrData),
    .chipRdData(chipRdData),
    .dmaWrEn   (dmaWrEn),
    .dmaIdx    (dmaIdx),
    .dmaWrData (dmaWrData),
    .dmaRdData (dmaRdData),
    .strobe    (strobe),
    .tgtId     (tgtId),
    .xferLen   (xferLen),
    .irq       (irq)
  );

endmodule

// File: rtl/hba_cmd_chk.sv
module hba_cmd_chk #(
  parameter int unsigned CHIP_AW = 6,
  parameter int unsigned DMA_AW  = 4,
  parameter int unsigned DMA_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               chipWrEn,
  input logic [CHIP_AW-1:0] chipAddr,
  input logic               dmaWrEn,
  input logic [DMA_AW-1:0]  dmaAddr,
  input logic [DMA_W-1:0]   dmaWrData,
  input logic               xferDone,
  input logic               cmdBusy,
  input logic               irq
);

  logic cmdWrite;
  logic dmaClearWr;
  assign cmdWrite   = chipWrEn && (chipAddr[CHIP_AW-1:2] == 3);
  assign dmaClearWr = dmaWrEn && (dmaAddr[DMA_AW-1:2] == 0) && !dmaWrData[4];

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && !xferDone |=> cmdBusy); // R10

  AST_DONE_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && xferDone |=> !cmdBusy && irq); // R8

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdBusy) |-> $past(cmdWrite)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(cmdWrite) || $past(cmdBusy && xferDone)); // R11

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(dmaClearWr)); // R11

  AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && xferDone && dmaClearWr |=> irq); // R12

endmodule

bind hba_cmd_regfile hba_cmd_chk #(
  .CHIP_AW(CHIP_AW),
  .DMA_AW (DMA_AW),
  .DMA_W  (DMA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chipWrEn (chipWrEn),
  .chipAddr (chipAddr),
  .dmaWrEn  (dmaWrEn),
  .dmaAddr  (dmaAddr),
  .dmaWrData(dmaWrData),
  .xferDone (xferDone),
  .cmdBusy  (cmdBusy),
  .irq      (irq)
);

// File: tb/tb_hba_cmd_regfile.sv
`timescale 1ns/100ps
module tb_hba_cmd_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipWrEn = 1'b0;
  logic [5:0]  chipAddr = '0;
  logic [7:0]  chipWrData = '0;
  logic [7:0]  chipRdData;
  logic        dmaWrEn = 1'b0;
  logic [3:0]  dmaAddr = '0;
  logic [31:0] dmaWrData = '0;
  logic [31:0] dmaRdData;
  logic [7:0]  targetPresent = 8'hFF;
  logic        xferDone = 1'b0;
  logic        cmdBusy;
  logic        irq;
  logic [15:0] xferLen;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model state
  logic [7:0]  mWr[16];
  logic [7:0]  mRd[16];
  logic [31:0] mDma[4];
  logic        mIrq;
  logic        mBusy;
  logic [6:0]  mPend;

  always #4 clk = ~clk;

  hba_cmd_regfile dut (
    .clk(clk), .rstN(rstN), .chipWrEn(chipWrEn), .chipAddr(chipAddr),
    .chipWrData(chipWrData), .chipRdData(chipRdData), .dmaWrEn(dmaWrEn),
    .dmaAddr(dmaAddr), .dmaWrData(dmaWrData), .dmaRdData(dmaRdData),
    .targetPresent(targetPresent), .xferDone(xferDone), .cmdBusy(cmdBusy),
    .irq(irq), .xferLen(xferLen)
  );

  // expected {status, interrupt, sequence} for a posted completion
  function automatic logic [23:0] codesFor(input logic [6:0] op, input bit absent);
    if (absent) return {8'h80, 8'h20, 8'h00};
    case (op)
      7'h10:   return {8'h93, 8'h10, 8'h00};
      7'h11:   return {8'h93, 8'h18, 8'h04};
      7'h12:   return {8'h93, 8'h20, 8'h00};
      default: return {8'h91, 8'h18, 8'h04};
    endcase
  endfunction

  function automatic bit isAbsent(input logic [7:0] tgtReg, input logic [7:0] pres);
    return (tgtReg[2:0] > 3'd4) || !pres[tgtReg[2:0]];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) begin
      mRd[i] = (i == 14) ? 8'h04 : 8'h00;
    end
    for (int i = 0; i < 4; i++) mDma[i] = '0;
  endtask

  task automatic post(input logic [23:0] c);
    mRd[4] = c[23:16];
    mRd[5] = c[15:8];
    mRd[6] = c[7:0];
    mDma[0][0] = 1'b1;
    mIrq = 1'b1;
  endtask

  task automatic modelStep(input bit cWe, input logic [3:0] cIdx, input logic [7:0] cDat,
                           input bit dWe, input logic [1:0] dIdx, input logic [31:0] dDat,
                           input bit done, input logic [7:0] pres);
    bit busy0;
    logic [7:0] tgtOld;
    logic [6:0] op;
    busy0  = mBusy;
    tgtOld = mWr[4];
    if (cWe) mWr[cIdx] = cDat;
    if (dWe) begin
      mDma[dIdx] = dDat;
      if (dIdx == 0 && !dDat[4]) mIrq = 1'b0;
    end
    if (busy0) begin
      if (done) begin
        post(codesFor(mPend, 1'b0));
        mBusy = 1'b0;
      end
    end else if (cWe && cIdx == 4'd3) begin
      op = cDat[6:0];
      case (op)
        7'h01: begin mRd[5] = 8'h08; mRd[6] = 8'h00; end
        7'h02: modelReset();
        7'h42, 7'h43: begin
          if (isAbsent(tgtOld, pres)) post(codesFor(op, 1'b1));
          else begin mBusy = 1'b1; mPend = op; end
        end
        7'h10, 7'h11, 7'h12: begin mBusy = 1'b1; mPend = op; end
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // sweep all visible state; called away from clock edges
  task automatic checkAll(input string tag);
    for (int i = 0; i < 16; i++) begin
      chipAddr = 6'(i << 2) | 6'(i & 3);
      #0.1;
      check(tag, $sformatf("rd[%0d]", i), 32'(chipRdData), 32'(mRd[i]));
    end
    for (int i = 0; i < 4; i++) begin
      dmaAddr = 4'(i << 2);
      #0.1;
      check(tag, $sformatf("dma[%0d]", i), dmaRdData, mDma[i]);
    end
    check(tag, "irq", 32'(irq), 32'(mIrq));
    check(tag, "busy", 32'(cmdBusy), 32'(mBusy));
    check(tag, "xferLen", 32'(xferLen), {16'h0, mWr[1], mWr[0]});
  endtask

  // one clock: inputs applied at negedge, checked after the edge
  task automatic step(input string tag, input bit cWe, input logic [3:0] cIdx,
                      input logic [7:0] cDat, input bit dWe, input logic [1:0] dIdx,
                      input logic [31:0] dDat, input bit done);
    chipWrEn   = cWe;
    chipAddr   = {cIdx, 2'b00};
    chipWrData = cDat;
    dmaWrEn    = dWe;
    dmaAddr    = {dIdx, 2'b00};
    dmaWrData  = dDat;
    xferDone   = done;
    @(posedge clk);
    #1;
    modelStep(cWe, cIdx, cDat, dWe, dIdx, dDat, done, targetPresent);
    chipWrEn = 1'b0;
    dmaWrEn  = 1'b0;
    xferDone = 1'b0;
    checkAll(tag);
    @(negedge clk);
  endtask

  task automatic cmd(input string tag, input logic [7:0] c);
    step(tag, 1'b1, 4'd3, c, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask
  task automatic wreg(input string tag, input logic [3:0] i, input logic [7:0] d);
    step(tag, 1'b1, i, d, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask
  task automatic dwr(input string tag, input logic [1:0] i, input logic [31:0] d);
    step(tag, 1'b0, 4'd0, 8'h0, 1'b1, i, d, 1'b0);
  endtask
  task automatic done1(input string tag);
    step(tag, 1'b0, 4'd0, 8'h0, 1'b0, 2'd0, 32'h0, 1'b1);
  endtask
  task automatic idle(input string tag);
    step(tag, 1'b0, 4'd0, 8'h0, 1'b0, 2'd0, 32'h0, 1'b0);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] opList[11];
    int unsigned r;
    opList = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12, 8'h1A, 8'h42, 8'h43, 8'h5C};
    for (int i = 0; i < 16; i++) mWr[i] = '0;
    modelReset();
    mIrq = 0; mBusy = 0; mPend = '0;
    r = $urandom(32'h00C0FFEE);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checkAll("R2");
    @(negedge clk);

    // R1: write bank and length
    wreg("R1", 4'd0, 8'h34);
    wreg("R1", 4'd1, 8'h12);
    wreg("R1", 4'd9, 8'hAB);

    // R4: flush after setting a status
    wreg("R7", 4'd4, 8'h05);          // target 5 is above the limit
    cmd("R7", 8'h42);                 // immediate disconnect
    cmd("R4", 8'h01);                 // status kept, intr 08, seq 00
    dwr("R11", 2'd0, 32'h0000_0010);  // bit4 set: irq stays
    dwr("R11", 2'd0, 32'hDEAD_BE00);  // bit4 clear: irq drops
    dwr("R11", 2'd2, 32'hCAFE_F00D);

    // R6: no-effect and unknown codes
    cmd("R6", 8'h00);
    cmd("R6", 8'h03);
    cmd("R6", 8'h1A);
    cmd("R6", 8'h77);

    // R3: bit 7 ignored (0x81 acts as flush)
    wreg("R3", 4'd5, 8'h00);
    cmd("R3", 8'h81);

    // R7: target absent by present bit
    targetPresent = 8'b1111_1011;
    wreg("R7", 4'd4, 8'hF2);          // low bits give target 2
    cmd("R7", 8'hC3);

    // R8: present target, busy, then done
    wreg("R8", 4'd4, 8'h01);
    cmd("R8", 8'h42);
    idle("R8");
    cmd("R10", 8'h02);                // ignored while busy
    done1("R8");
    done1("R10");                     // done while idle: no effect

    // R9: transfer commands
    dwr("R11", 2'd0, 32'h0);
    cmd("R9", 8'h10); done1("R9");
    cmd("R9", 8'h11); done1("R9");
    cmd("R9", 8'h92); done1("R9");

    // R12: completion with a clearing DMA write in the same cycle
    cmd("R12", 8'h10);
    step("R12", 1'b0, 4'd0, 8'h0, 1'b1, 2'd0, 32'h0000_0A00, 1'b1);

    // R5: chip reset keeps write bank and irq
    cmd("R5", 8'h02);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      bit cWe, dWe, dn;
      logic [3:0] cIdx;
      logic [7:0] cDat;
      if (n % 100 == 0) targetPresent = 8'($urandom);
      cWe  = ($urandom % 2) == 0;
      cIdx = ($urandom % 3 == 0) ? 4'd3 : 4'($urandom);
      cDat = 8'($urandom);
      if (cIdx == 4'd3) begin
        cDat = opList[$urandom % 11] | {$urandom % 2 == 0, 7'h0};
        if (cDat[6:0] == 7'h02 && ($urandom % 4 != 0)) cDat = 8'h42;
      end
      if (cIdx == 4'd4) cDat = 8'($urandom % 8);
      dWe = ($urandom % 4) == 0;
      dn  = ($urandom % 3) == 0;
      step("R1", cWe, cIdx, cDat, dWe, 2'($urandom), ($urandom % 2 == 0) ? 32'($urandom) & ~32'h10 : 32'($urandom), dn);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule